// File: doc/BRIEF.md
# Lighting Lookup Table Unit

This block holds the response tables used by a fragment lighting stage and answers lookups into them. Software loads the tables through two write ports. The first write sets a pointer that names a table and an entry. Each later data write stores one entry at that pointer and then moves the pointer to the next entry. Each stored entry holds an unsigned sample and a signed slope toward the next entry.

A lookup supplies a fixed-point dot product, a table code and per-request settings: index signedness, an absolute-value flag and an output scale code. A separate vector disables individual tables. The unit turns the dot product into an entry number and a 5-bit sub-step fraction, then reads the entry. It adds the slope weighted by the fraction, clamps the sum to a 12-bit fraction and applies the scale. A missed lookup returns zero with the hit flag low. A lookup misses when the table is unused, not built, or disabled. The number of per-light tables is a parameter. Each light has one spot table and one distance table.

Top module: `lightlut_unit`

## Requirements
- R1: A pointer write (`idx_we`) loads the entry number from `idx_wdata[7:0]` and the table code from `idx_wdata[12:8]`. The next data write lands in that table at that entry.
- R2: A data write (`dat_we`) stores the sample from `dat_wdata[11:0]` (unsigned, 1/4096 units) and the slope from `dat_wdata[23:12]` (two's complement). It then advances the pointer entry by one, and entry 255 wraps to entry 0 of the same table.
- R3: Table codes are 0, 1, 3, 4, 5, 6, 8+L and 16+L, for L below `NUM_LIGHTS`. Any other code returns a miss, with `res_hit` 0 and `res_value` 0. A data write while the pointer holds such a code changes no table.
- R4: Unsigned indexing uses `lk_dot` as a signed fixed-point number with `DOT_FRAC` fraction bits. The index is floor(dot*256), clamped to 0..255. The fraction is the next 4 bits, doubled to 5-bit units, and is 0 when clamping occurs.
- R5: Signed indexing (`lk_signed`=1) uses floor(dot*128), clamped to -128..127. The fraction is the next 5 bits, and is 0 when clamped. The entry read is the low 8 bits of the index, so negative indices read entries 128..255.
- R6: In unsigned mode, `lk_abs`=1 replaces a negative dot product by its magnitude. In signed mode `lk_abs` has no effect.
- R7: The result before scaling is sample + floor(slope*fraction/32), clamped to 0..4095.
- R8: Scale code 0/1/2/3 multiplies the clamped result by 1/2/4/8. Code 6 divides it by 4 and code 7 divides it by 2, both truncating. Codes 4 and 5 multiply by 1.
- R9: A lookup into a table whose bit in `tbl_disable` (indexed by table code) is set returns a miss.
- R10: Each lookup yields one `res_valid` pulse two clock edges after `lk_valid` is sampled. While `res_valid` is low, `res_hit` and `res_value` are 0.
- R11: After reset, the outputs are 0 and the pointer is table 0, entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Pointer write strobe |
| idx_wdata | input | 13 | Entry number [7:0], table code [12:8] |
| dat_we | input | 1 | Data write strobe |
| dat_wdata | input | 24 | Sample [11:0], slope [23:12] |
| tbl_disable | input | 24 | One disable bit per table code |
| lk_valid | input | 1 | Lookup request |
| lk_table | input | 5 | Table code of the lookup |
| lk_dot | input | DOT_W | Signed fixed-point dot product |
| lk_signed | input | 1 | Signed index mode |
| lk_abs | input | 1 | Magnitude before unsigned indexing |
| lk_scale | input | 3 | Output scale code |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | Lookup found an active table |
| res_value | output | 15 | Scaled result, 1/4096 units |

## Verification
The pointer and table contents change on the edge that samples a write. A lookup result is registered on the second edge after the request. The bench raises `lk_valid` for one cycle at a falling edge, waits two falling edges, and samples all three outputs there. At that point both internal stages have settled. The bench inserts no lookup in the same cycle as a write, so each read sees the contents already committed.

// File: rtl/lightlut_unit.sv
module lightlut_unit #(
  parameter int DOT_W      = 16,
  parameter int DOT_FRAC   = 12,
  parameter int NUM_LIGHTS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    idx_we,
  input  logic [12:0]             idx_wdata,
  input  logic                    dat_we,
  input  logic [23:0]             dat_wdata,
  input  logic [23:0]             tbl_disable,
  input  logic                    lk_valid,
  input  logic [4:0]              lk_table,
  input  logic signed [DOT_W-1:0] lk_dot,
  input  logic                    lk_signed,
  input  logic                    lk_abs,
  input  logic [2:0]              lk_scale,
  output logic                    res_valid,
  output logic                    res_hit,
  output logic [14:0]             res_value
);

  localparam int SLOTS = 6 + 2 * NUM_LIGHTS;
  localparam int SW    = $clog2(SLOTS);
  localparam int DEPTH = SLOTS * 256;
  localparam int US    = DOT_FRAC - 8;
  localparam int SS    = DOT_FRAC - 7;

  function automatic logic [SW:0] slot_of(input logic [4:0] c);
    int  s;
    logic ok;
    ok = 1'b1;
    s  = 0;
    if (c <= 5'd1)                             s = int'(c);
    else if (c >= 5'd3 && c <= 5'd6)           s = int'(c) - 1;
    else if (int'(c) >= 8 && int'(c) < 8 + NUM_LIGHTS)   s = int'(c) - 2;
    else if (int'(c) >= 16 && int'(c) < 16 + NUM_LIGHTS) s = int'(c) - 10 + NUM_LIGHTS;
    else ok = 1'b0;
    return {ok, SW'(s)};
  endfunction

  logic [23:0] mem [DEPTH];

  logic [7:0]  wr_ent;
  logic [4:0]  wr_tbl;
  logic [SW:0] wslot;
  assign wslot = slot_of(wr_tbl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ent <= '0;
      wr_tbl <= '0;
    end else if (idx_we) begin
      wr_ent <= idx_wdata[7:0];
      wr_tbl <= idx_wdata[12:8];
    end else if (dat_we) begin
      wr_ent <= wr_ent + 8'd1;
    end
  end

  logic signed [DOT_W:0] dx, mag, qu, qs;
  assign dx  = {lk_dot[DOT_W-1], lk_dot};
  assign mag = (!lk_signed && lk_abs && dx < 0) ? -dx : dx;
  assign qu  = mag >>> US;
  assign qs  = mag >>> SS;

  logic [7:0] ent;
  logic [4:0] fr;
  always_comb begin
    if (lk_signed) begin
      if (qs < -128) begin
        ent = 8'h80; fr = '0;
      end else if (qs > 127) begin
        ent = 8'h7f; fr = '0;
      end else begin
        ent = qs[7:0]; fr = mag[SS-1 -: 5];
      end
    end else begin
      if (qu < 0) begin
        ent = 8'h00; fr = '0;
      end else if (qu > 255) begin
        ent = 8'hff; fr = '0;
      end else begin
        ent = qu[7:0]; fr = {mag[US-1 -: 4], 1'b0};
      end
    end
  end

  logic [SW:0] rslot;
  logic [31:0] dis32;
  logic        rd_en;
  assign rslot = slot_of(lk_table);
  assign dis32 = {8'h00, tbl_disable};
  assign rd_en = lk_valid && rslot[SW] && !dis32[lk_table];

  logic [23:0] rd_q;
  always_ff @(posedge clk) begin
    if (dat_we && !idx_we && wslot[SW]) mem[{wslot[SW-1:0], wr_ent}] <= dat_wdata;
    if (rd_en) rd_q <= mem[{rslot[SW-1:0], ent}];
  end

  logic       s1_valid, s1_hit;
  logic [4:0] s1_frac;
  logic [2:0] s1_scale;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_hit   <= 1'b0;
      s1_frac  <= '0;
      s1_scale <= '0;
    end else begin
      s1_valid <= lk_valid;
      s1_hit   <= rd_en;
      s1_frac  <= fr;
      s1_scale <= lk_scale;
    end
  end

  logic signed [11:0] dlt;
  logic signed [17:0] prod, prod_sh;
  logic signed [19:0] sum;
  logic [11:0]        clp;
  logic [14:0]        scl;
  assign dlt     = rd_q[23:12];
  assign prod    = dlt * $signed({1'b0, s1_frac});
  assign prod_sh = prod >>> 5;
  assign sum     = 20'($signed({1'b0, rd_q[11:0]})) + 20'(prod_sh);
  assign clp     = (sum < 0) ? 12'd0 : (sum > 4095) ? 12'd4095 : sum[11:0];

  always_comb begin
    case (s1_scale)
      3'd1:    scl = 15'(clp) << 1;
      3'd2:    scl = 15'(clp) << 2;
      3'd3:    scl = 15'(clp) << 3;
      3'd6:    scl = 15'(clp) >> 2;
      3'd7:    scl = 15'(clp) >> 1;
      default: scl = 15'(clp);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_value <= '0;
    end else begin
      res_valid <= s1_valid;
      res_hit   <= s1_valid && s1_hit;
      res_value <= (s1_valid && s1_hit) ? scl : 15'd0;
    end
  end

endmodule

// File: rtl/lightlut_unit_chk.sv
module lightlut_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [23:0] tbl_disable,
  input logic        lk_valid,
  input logic [4:0]  lk_table,
  input logic [2:0]  lk_scale,
  input logic        res_valid,
  input logic        res_hit,
  input logic [14:0] res_value
);

  logic [31:0] dis_ext;
  assign dis_ext = {8'h00, tbl_disable};

  AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ##2 res_valid); // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(lk_valid, 2)); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_value == 15'd0 && !res_hit)); // R10
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> res_value == 15'd0); // R3
  AST_UNUSED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && (lk_table == 5'd2 || lk_table == 5'd7 || lk_table > 5'd23)) |-> ##2 !res_hit); // R3
  AST_DISABLED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && dis_ext[lk_table]) |-> ##2 !res_hit); // R9
  AST_UNITY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_scale == 3'd0) |-> ##2 res_value <= 15'd4095); // R7
  AST_QUARTER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_scale == 3'd6) |-> ##2 res_value <= 15'd1023); // R8
  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_scale == 3'd7) |-> ##2 res_value <= 15'd2047); // R8

endmodule

bind lightlut_unit lightlut_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tbl_disable(tbl_disable), .lk_valid(lk_valid),
  .lk_table(lk_table), .lk_scale(lk_scale), .res_valid(res_valid),
  .res_hit(res_hit), .res_value(res_value)
);

// File: tb/lightlut_unit_tb.sv
module lightlut_unit_tb;
  localparam int NL = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_we = 1'b0;
  logic [12:0] idx_wdata = '0;
  logic        dat_we = 1'b0;
  logic [23:0] dat_wdata = '0;
  logic [23:0] tbl_disable = '0;
  logic        lk_valid = 1'b0;
  logic [4:0]  lk_table = '0;
  logic signed [15:0] lk_dot = '0;
  logic        lk_signed = 1'b0;
  logic        lk_abs = 1'b0;
  logic [2:0]  lk_scale = '0;
  logic        res_valid, res_hit;
  logic [14:0] res_value;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  int mdl [24][256];
  int p_ent = 0;
  int p_tbl = 0;

  always #2 clk = ~clk;

  lightlut_unit u_dut (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_wdata(idx_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .tbl_disable(tbl_disable),
    .lk_valid(lk_valid), .lk_table(lk_table), .lk_dot(lk_dot),
    .lk_signed(lk_signed), .lk_abs(lk_abs), .lk_scale(lk_scale),
    .res_valid(res_valid), .res_hit(res_hit), .res_value(res_value)
  );

  function automatic bit impl(int c);
    return (c == 0 || c == 1 || (c >= 3 && c <= 6) ||
            (c >= 8 && c < 8 + NL) || (c >= 16 && c < 16 + NL));
  endfunction

  function automatic int expect_val(int c, int d, bit sg, bit ab, int sc, output bit hit);
    int m, q, f, v, dl, r;
    hit = impl(c) && !tbl_disable[c % 24] && c < 24;
    if (!hit) return 0;
    if (sg) begin
      q = d >>> 5; f = d & 31;
      if (q < -128) begin q = -128; f = 0; end
      else if (q > 127) begin q = 127; f = 0; end
    end else begin
      m = (ab && d < 0) ? -d : d;
      q = m >>> 4; f = (m & 15) * 2;
      if (q < 0) begin q = 0; f = 0; end
      else if (q > 255) begin q = 255; f = 0; end
    end
    v  = mdl[c][q & 255] & 4095;
    dl = (mdl[c][q & 255] >> 12) & 4095;
    if (dl >= 2048) dl -= 4096;
    r = v + ((dl * f) >>> 5);
    if (r < 0) r = 0;
    if (r > 4095) r = 4095;
    case (sc)
      1: r = r * 2;
      2: r = r * 4;
      3: r = r * 8;
      6: r = r >> 2;
      7: r = r >> 1;
      default: ;
    endcase
    return r;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic set_ptr(int c, int e);
    @(negedge clk);
    idx_we = 1'b1; idx_wdata = 13'((c << 8) | e);
    @(negedge clk);
    idx_we = 1'b0;
    p_tbl = c; p_ent = e;
  endtask

  task automatic put(int w);
    @(negedge clk);
    dat_we = 1'b1; dat_wdata = 24'(w);
    if (impl(p_tbl)) mdl[p_tbl][p_ent] = w & 24'hffffff;
    p_ent = (p_ent + 1) & 255;
    @(negedge clk);
    dat_we = 1'b0;
  endtask

  task automatic look(int c, int d, bit sg, bit ab, int sc, string tag);
    int e; bit h;
    @(negedge clk);
    lk_valid = 1'b1; lk_table = 5'(c); lk_dot = 16'(d);
    lk_signed = sg; lk_abs = ab; lk_scale = 3'(sc);
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
    e = expect_val(c, d, sg, ab, sc, h);
    check(res_valid === 1'b1, tag, "res_valid", int'(res_valid), 1);
    check(res_hit === h, tag, "res_hit", int'(res_hit), int'(h));
    check(res_value === 15'(e), tag, "res_value", int'(res_value), e);
  endtask

  task automatic fill_table(int c, bit use_ptr);
    if (use_ptr) set_ptr(c, 0);
    @(negedge clk);
    dat_we = 1'b1;
    for (int i = 0; i < 256; i++) begin
      dat_wdata = 24'($urandom);
      mdl[c][p_ent] = int'(dat_wdata);
      p_ent = (p_ent + 1) & 255;
      @(negedge clk);
    end
    dat_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int codes [10] = '{0, 1, 3, 4, 5, 6, 8, 9, 16, 17};
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check(res_valid === 1'b0 && res_hit === 1'b0 && res_value === 15'd0, "R11",
          "outputs in reset", int'(res_value), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid === 1'b0 && res_value === 15'd0, "R11", "outputs after reset", int'(res_valid), 0);

    // R11: pointer starts at table 0 entry 0
    fill_table(0, 1'b0);
    look(0, 0, 0, 0, 0, "R11");
    look(0, 16 * 37 + 5, 0, 0, 0, "R11");
    for (int i = 1; i < 10; i++) fill_table(codes[i], 1'b1);

    // R1 pointer fields
    set_ptr(16, 77);
    put(24'h012345);
    look(16, 77 * 16, 0, 0, 0, "R1");
    look(16, 77 * 32, 1, 0, 0, "R1");

    // R2 auto increment and wrap
    set_ptr(3, 254);
    put(24'h000111); put(24'h000222); put(24'h000333);
    look(3, 254 * 16, 0, 0, 0, "R2");
    look(3, 255 * 16, 0, 0, 0, "R2");
    look(3, 0, 0, 0, 0, "R2");
    check(res_value === 15'h333, "R2", "wrapped entry", int'(res_value), 'h333);

    // R3 unused codes and ignored writes
    set_ptr(2, 5);
    put(24'h000fff);
    look(1, 5 * 16, 0, 0, 0, "R3");
    look(2, 5 * 16, 0, 0, 0, "R3");
    look(7, 100, 0, 0, 0, "R3");
    look(10, 100, 0, 0, 0, "R3");
    look(18, 100, 0, 0, 0, "R3");
    look(25, 100, 0, 0, 0, "R3");

    // R4 unsigned index and clamps
    look(5, 255 * 16 + 15, 0, 0, 0, "R4");
    look(5, 5000, 0, 0, 0, "R4");
    look(5, -300, 0, 0, 0, "R4");
    look(5, 40 * 16 + 7, 0, 0, 0, "R4");

    // R5 signed index, negative entries and clamps
    look(6, -32, 1, 0, 0, "R5");
    look(6, -5000, 1, 0, 0, "R5");
    look(6, 5000, 1, 0, 0, "R5");
    look(6, -100, 1, 0, 0, "R5");

    // R6 absolute-value flag
    look(8, -100, 0, 1, 0, "R6");
    look(8, -100, 1, 1, 0, "R6");

    // R7 interpolation and clamps
    set_ptr(4, 40);
    put((2047 << 12) | 4090);
    put((2048 << 12) | 3);
    look(4, 40 * 16 + 15, 0, 0, 0, "R7");
    check(res_value === 15'd4095, "R7", "upper clamp", int'(res_value), 4095);
    look(4, 41 * 16 + 8, 0, 0, 0, "R7");
    check(res_value === 15'd0, "R7", "lower clamp", int'(res_value), 0);
    look(4, 40 * 32 + 17, 1, 0, 0, "R7");

    // R8 every scale code
    for (int s = 0; s < 8; s++) look(9, 123, 0, 0, s, "R8");
    look(4, 40 * 16 + 15, 0, 0, 3, "R8");

    // R9 disabled table
    tbl_disable = 24'h000002;
    look(1, 300, 0, 0, 0, "R9");
    look(0, 300, 0, 0, 0, "R9");
    tbl_disable = '0;
    look(1, 300, 0, 0, 0, "R9");

    // R10 random mix
    for (int i = 0; i < 400; i++) begin
      int c;
      c = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 31)) : codes[$urandom_range(0, 9)];
      tbl_disable = ($urandom_range(0, 7) == 0) ? 24'($urandom) : 24'h0;
      look(c, int'($urandom_range(0, 20480)) - 10240, 1'($urandom), 1'($urandom),
           int'($urandom_range(0, 7)), "R10");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule